// File: doc/BRIEF.md
# I2C target address matcher

This block is the addressing front end of an I2C target. It watches the two bus lines through a synchronizer running on the system clock. It recognizes start, repeated start and stop conditions, and it collects the address byte or bytes that follow each start. Those bytes are compared with a programmed own address, in either 7-bit or 10-bit form.

When an address selects this target, the block pulls SDA low for the acknowledge clock. It then gives a one-cycle `match_o` pulse, and `rnw_o` carries the direction bit. A general call (address byte 0x00) is acknowledged only when enabled, and it is reported on a separate pulse. After the address phase the block stays silent until the next start or stop. Data bytes are handled elsewhere.

In 10-bit mode the first byte is `11110 A9 A8 R/W` and the second byte is `A7..A0`. The target is selected only when both bytes match. After a complete 10-bit write selection, a repeated start followed by `11110 A9 A8 1` alone selects the same target again for reading.

Top module: `i2cam_matcher`

## Requirements
- R1: A start or stop is recognized only from an SDA transition while SCL is high. An SDA fall while SCL is low does not begin address reception, so a following address byte is not acknowledged.
- R2: In 7-bit mode, a byte (MSB first) whose bits 7..1 equal `own_addr_i[6:0]` is acknowledged. SDA is held low during the whole high phase of the ninth clock. A `match_o` pulse is given with `rnw_o` equal to bit 0 of the byte (1 = read, 0 = write).
- R3: A first byte that selects nothing is not acknowledged and produces neither a `match_o` pulse nor a `gcall_o` pulse.
- R4: The byte 0x00 is acknowledged with a `gcall_o` pulse (and no `match_o`) only when `gc_en_i` is 1. With `gc_en_i` at 0 it is not acknowledged. The byte 0x01 is never treated as a general call.
- R5: In 10-bit mode, a first byte `11110 A9 A8 0` with A9 A8 equal to `own_addr_i[9:8]` is acknowledged without a `match_o` pulse. A second byte equal to `own_addr_i[7:0]` is then acknowledged with a `match_o` pulse and `rnw_o` = 0.
- R6: In 10-bit mode, a mismatching second byte is not acknowledged and gives no `match_o` pulse. A first byte whose A9 A8 differ from the own address is not acknowledged.
- R7: After a full 10-bit selection, a repeated start followed by `11110 A9 A8 1` is acknowledged with a `match_o` pulse and `rnw_o` = 1. The same byte after a stop, with no prior selection, is not acknowledged.
- R8: A stop, or a new start, arriving while address bits are being shifted in discards the partial byte. The address that follows the next start is decoded from scratch.
- R9: After reset `sda_low_o`, `match_o` and `gcall_o` are 0.
- R10: SDA is released once the ninth clock ends. `sda_low_o` is 0 by the middle of the following SCL low phase, and it only ever rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr_i | input | 10 | Programmed own address; bits 6..0 used in 7-bit mode |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| gc_en_i | input | 1 | 1 enables acknowledging the general call |
| sda_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| match_o | output | 1 | One-cycle pulse when this target is selected |
| rnw_o | output | 1 | Direction of the last selection, 1 = read |
| gcall_o | output | 1 | One-cycle pulse when a general call is acknowledged |

## Verification
The hardest state to reach is the 10-bit re-selection for reading. It needs a fully acknowledged two-byte write header, then a repeated start with no stop in between, and then a read header. The bench drives that exact sequence. It then repeats the read header after a stop, to show that the remembered selection is gone.

Aborts are reached by cutting a byte after a few bits with a stop or a repeated start. The bench then sends the own address and expects it to be acknowledged. Acknowledge timing is observed on the modelled wired-AND data line during the ninth clock high phase.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

    localparam int BYTE_W = 8;
    localparam int OWN_W  = 10;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ACK1,
        ST_ADDR2,
        ST_ACK2,
        ST_PASS
    } am_state_e;

    // Conditions decoded from the synchronized bus lines
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    // Decision taken on a completed first address byte
    typedef struct packed {
        logic ack;
        logic match;
        logic gcall;
        logic rnw;
        logic to_second;
    } verdict_t;

    function automatic verdict_t judge_first(
        input logic [BYTE_W-1:0] b,
        input logic [OWN_W-1:0]  own,
        input logic              ten,
        input logic              gc_en,
        input logic              ten_sel
    );
        verdict_t v;
        v     = '0;
        v.rnw = b[0];
        if (b == '0) begin
            v.ack   = gc_en;
            v.gcall = gc_en;
        end else if (!ten) begin
            if (b[7:1] == own[6:0]) begin
                v.ack   = 1'b1;
                v.match = 1'b1;
            end
        end else if (b[7:3] == TEN_HDR && b[2:1] == own[9:8]) begin
            if (!b[0]) begin
                v.ack       = 1'b1;
                v.to_second = 1'b1;
            end else if (ten_sel) begin
                v.ack   = 1'b1;
                v.match = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/i2cam_sync.sv
module i2cam_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    always_ff @(posedge clk) begin
        if (rst) r <= '1;
        else     r <= {r[STAGES-2:0], d};
    end

    assign q = r[STAGES-1];
endmodule

// File: rtl/i2cam_cond.sv
module i2cam_cond
    import i2cam_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now;
    logic [LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        i2cam_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[i]),
            .q   (now[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prv <= '1;
        else     prv <= now;
    end

    // index 1 = SCL, index 0 = SDA
    always_comb begin
        ev.scl      = now[1];
        ev.sda      = now[0];
        ev.scl_rise = !prv[1] && now[1];
        ev.scl_fall = prv[1] && !now[1];
        ev.start    = prv[1] && now[1] && prv[0] && !now[0];
        ev.stop     = prv[1] && now[1] && !prv[0] && now[0];
    end

    p_cond_edge_r1: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |-> $past(now[1]) && $stable(now[1]));
endmodule

// File: rtl/i2cam_fsm.sv
module i2cam_fsm
    import i2cam_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [OWN_W-1:0] own_addr_i,
    input  logic             ten_bit_i,
    input  logic             gc_en_i,
    output logic             sda_low_o,
    output logic             match_o,
    output logic             rnw_o,
    output logic             gcall_o
);
    am_state_e         state;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              ten_sel;
    logic              to_second_q;
    verdict_t          v;
    logic              byte_done;

    always_comb v = judge_first(sh, own_addr_i, ten_bit_i, gc_en_i, ten_sel);
    assign byte_done = ev.scl_fall && (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            sh          <= '0;
            cnt         <= '0;
            ten_sel     <= 1'b0;
            to_second_q <= 1'b0;
            sda_low_o   <= 1'b0;
            match_o     <= 1'b0;
            rnw_o       <= 1'b0;
            gcall_o     <= 1'b0;
        end else begin
            match_o <= 1'b0;
            gcall_o <= 1'b0;
            if (ev.stop) begin
                state     <= ST_IDLE;
                cnt       <= '0;
                ten_sel   <= 1'b0;
                sda_low_o <= 1'b0;
            end else if (ev.start) begin
                state     <= ST_ADDR1;
                cnt       <= '0;
                sda_low_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR1, ST_ADDR2: begin
                        if (ev.scl_rise && cnt < CNT_W'(BYTE_W)) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_ADDR1) begin
                                ten_sel     <= ten_sel && (v.to_second || (v.match && ten_bit_i));
                                to_second_q <= v.to_second;
                                if (v.ack) begin
                                    sda_low_o <= 1'b1;
                                    state     <= ST_ACK1;
                                    match_o   <= v.match;
                                    gcall_o   <= v.gcall;
                                    if (v.match) rnw_o <= v.rnw;
                                end else begin
                                    state <= ST_PASS;
                                end
                            end else if (sh == own_addr_i[BYTE_W-1:0]) begin
                                sda_low_o <= 1'b1;
                                state     <= ST_ACK2;
                                match_o   <= 1'b1;
                                rnw_o     <= 1'b0;
                                ten_sel   <= 1'b1;
                            end else begin
                                ten_sel <= 1'b0;
                                state   <= ST_PASS;
                            end
                        end
                    end
                    ST_ACK1: begin
                        if (ev.scl_fall) begin
                            sda_low_o <= 1'b0;
                            state     <= to_second_q ? ST_ADDR2 : ST_PASS;
                        end
                    end
                    ST_ACK2: begin
                        if (ev.scl_fall) begin
                            sda_low_o <= 1'b0;
                            state     <= ST_PASS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_ack_rise_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low_o) |-> !ev.scl);
    p_match_with_ack_r2: assert property (@(posedge clk) disable iff (rst)
        match_o |-> sda_low_o);
    p_match_gc_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(match_o && gcall_o));
    p_gc_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
        gcall_o |-> $past(gc_en_i));
    p_stop_releases_r8: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_low_o && !match_o);
endmodule

// File: rtl/i2cam_matcher.sv
module i2cam_matcher
    import i2cam_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [OWN_W-1:0] own_addr_i,
    input  logic             ten_bit_i,
    input  logic             gc_en_i,
    output logic             sda_low_o,
    output logic             match_o,
    output logic             rnw_o,
    output logic             gcall_o
);
    bus_ev_t ev;

    i2cam_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cam_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .own_addr_i (own_addr_i),
        .ten_bit_i  (ten_bit_i),
        .gc_en_i    (gc_en_i),
        .sda_low_o  (sda_low_o),
        .match_o    (match_o),
        .rnw_o      (rnw_o),
        .gcall_o    (gcall_o)
    );
endmodule

// File: tb/test_i2cam_matcher.sv
module test_i2cam_matcher;
    localparam int T = 20;

    typedef struct {
        bit    gc;
        bit    rnw;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [9:0] own = 10'h2C7;
    logic       ten = 1'b0;
    logic       gc_en = 1'b1;
    logic       sda_low, match, rnw, gcall;
    logic       sda_bus;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t q[$];

    assign sda_bus = sda_m & ~sda_low;

    always #4 clk = ~clk;

    i2cam_matcher i_i2cam_matcher (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .own_addr_i (own),
        .ten_bit_i  (ten),
        .gc_en_i    (gc_en),
        .sda_low_o  (sda_low),
        .match_o    (match),
        .rnw_o      (rnw),
        .gcall_o    (gcall)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (match || gcall)) begin
            if (q.size() == 0) begin
                chk(0, "R3", "unexpected select pulse (match,gcall)", {match, gcall}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(gcall == e.gc && match == !e.gc, e.req, "pulse kind gcall",
                    int'(gcall), int'(e.gc));
                if (!e.gc) chk(rnw == e.rnw, e.req, "direction rnw", int'(rnw), int'(e.rnw));
            end
        end
    end

    task automatic wt();
        repeat (T) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt();
        scl_m = 1'b1; wt();
        sda_m = 1'b0; wt();
        scl_m = 1'b0; wt();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt();
        scl_m = 1'b1; wt();
        sda_m = 1'b1; wt();
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wt();
        scl_m = 1'b1; wt(); wt();
        scl_m = 1'b0; wt();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ackd, output bit rel);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wt();
        scl_m = 1'b1; wt();
        ackd = !sda_bus;
        wt();
        scl_m = 1'b0; wt();
        rel = !sda_low;
    endtask

    task automatic expect_ack(input logic [7:0] b, input bit exp, input string req);
        bit a, r;
        send_byte(b, a, r);
        chk(a == exp, req, $sformatf("ack for byte 0x%02h", b), int'(a), int'(exp));
        if (a) chk(r, "R10", "SDA released after ninth clock", int'(r), 1);
    endtask

    task automatic pending(input string req);
        chk(q.size() == 0, req, "expected pulses still pending", q.size(), 0);
        q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(sda_low == 0 && match == 0 && gcall == 0, "R9", "outputs in reset",
            {sda_low, match, gcall}, 0);
        rst = 1'b0;
        wt();
        chk(sda_low == 0 && match == 0 && gcall == 0, "R9", "outputs after reset",
            {sda_low, match, gcall}, 0);

        // R2: 7-bit write and read of own address 0x47
        bus_start();
        q.push_back('{gc: 0, rnw: 0, req: "R2"});
        expect_ack(8'h8E, 1, "R2");
        bus_stop();
        pending("R2");
        bus_start();
        q.push_back('{gc: 0, rnw: 1, req: "R2"});
        expect_ack(8'h8F, 1, "R2");
        bus_stop();
        pending("R2");

        // R3: other address
        bus_start();
        expect_ack(8'h90, 0, "R3");
        chk(sda_low == 0, "R3", "SDA not driven", int'(sda_low), 0);
        bus_stop();

        // R4: general call
        bus_start();
        q.push_back('{gc: 1, rnw: 0, req: "R4"});
        expect_ack(8'h00, 1, "R4");
        bus_stop();
        pending("R4");
        bus_start();
        expect_ack(8'h01, 0, "R4");
        bus_stop();
        gc_en = 1'b0;
        bus_start();
        expect_ack(8'h00, 0, "R4");
        bus_stop();
        gc_en = 1'b1;

        // R1: SDA falls while SCL low, no start condition
        scl_m = 1'b0; wt();
        sda_m = 1'b0; wt();
        expect_ack(8'h8E, 0, "R1");
        bus_stop();

        // R8: stop in the middle of an address byte
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        bus_start();
        q.push_back('{gc: 0, rnw: 0, req: "R8"});
        expect_ack(8'h8E, 1, "R8");
        bus_stop();
        pending("R8");
        // R8: repeated start in the middle of an address byte
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        q.push_back('{gc: 0, rnw: 1, req: "R8"});
        expect_ack(8'h8F, 1, "R8");
        bus_stop();
        pending("R8");

        // 10-bit mode, own 0x2C7: header write 0xF4, read 0xF5, low byte 0xC7
        ten = 1'b1;
        bus_start();
        expect_ack(8'hF4, 1, "R5");
        pending("R5");
        q.push_back('{gc: 0, rnw: 0, req: "R5"});
        expect_ack(8'hC7, 1, "R5");
        pending("R5");
        bus_start();
        q.push_back('{gc: 0, rnw: 1, req: "R7"});
        expect_ack(8'hF5, 1, "R7");
        bus_stop();
        pending("R7");

        // R7: read header without prior selection
        bus_start();
        expect_ack(8'hF5, 0, "R7");
        bus_stop();

        // R6: second byte mismatch, then wrong upper bits
        bus_start();
        expect_ack(8'hF4, 1, "R6");
        expect_ack(8'hC6, 0, "R6");
        bus_stop();
        bus_start();
        expect_ack(8'hF2, 0, "R6");
        bus_stop();
        pending("R6");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule